// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block sits between one processor and a shared, atomic bus. It keeps a small direct-mapped, write-back cache whose lines each carry a tag, a one-word data field and three state bits: valid, exclusive (clear means the line is held shared), and dirty. Processor reads and writes either complete at once or stall while the controller wins the bus and runs the transactions it needs. At the same time the block watches the transactions that other caches place on the bus. It reports copies it holds, gives up ownership, and supplies modified data in place of memory.

The processor side is a valid/ready request channel. A request is raised with `cpu_valid` and must hold its address, direction and write data unchanged until the cycle in which `cpu_ready` is high. That cycle is the hit, and read data is returned in it. A cycle with `cpu_valid` high and `cpu_ready` low is a stall. The bus side is plain control. `bus_req` is held until `bus_gnt`. Each grant cycle is one complete transaction: the controller drives `bus_cmd`/`bus_addr`/`bus_wdata` and, in the same cycle, samples the fill word and the wired shared-line. Bus commands are encoded as 0 = idle, 1 = read miss, 2 = write miss, 3 = write-back. The low `IDX_W` bits of an address select the line, and the upper bits form the tag.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first request to any address stalls and raises `bus_req` one cycle later. No bus command, shared or abort output is active while inputs are idle.
- R2: A read that matches a valid line asserts `cpu_ready` in the same cycle with the stored word on `cpu_rdata` and no bus request. An unanswered request holds its fields stable.
- R3: A read miss raises `bus_req` the cycle after the request, issues command 1 with the request address in the grant cycle, and fills the line. The line is filled exclusive if `bus_shared_in` is low and shared if it is high. The read then hits on the following cycle.
- R4: A write that matches an exclusive line completes in the same cycle and marks the line dirty, with no bus request.
- R5: A write that matches a shared line stalls and issues command 2 in its grant cycle. It keeps its own data and dirty state, takes exclusive ownership, and completes the cycle after the grant.
- R6: `bus_cmd` is non-zero only in a cycle with `bus_gnt` high. While a fill is waiting for the bus, `bus_req` stays high.
- R7: A snooped read miss (command 1) that matches a valid line drives `snp_shared` in that cycle and leaves the line shared, so a later local write to it needs the bus.
- R8: A snooped read miss or write miss that matches a dirty line asserts `snp_abort` and drives the line's word on `snp_data` in the same cycle.
- R9: A snooped write miss (command 2) that matches a line invalidates it, so the next local access to that address misses.
- R10: A miss whose line holds a different dirty block first issues command 3 with the victim's address and word, then the fill. If a snooped write miss invalidates the victim while the write-back waits, the write-back is dropped and the fill is issued directly.
- R11: In a cycle where a snooped transaction selects the same line index as the pending processor request, `cpu_ready` stays low and the request is retried next cycle.
- R12: Snooped write-backs (command 3) produce no shared, abort or state change.
- R13: A write miss issues command 2, fills the line exclusive, and completes the write on the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_wr | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Request completes this cycle (hit) |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_ready` on reads |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted for this cycle |
| bus_cmd | output | 2 | Own transaction: 0 idle, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of own transaction |
| bus_wdata | output | DATA_W | Word carried by a write-back |
| bus_fill_data | input | DATA_W | Fill word returned during own grant cycle |
| bus_shared_in | input | 1 | Wired shared-line seen during own read miss |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | Drives the shared-line: copy held |
| snp_abort | output | 1 | Abort memory: this cache supplies the word |
| snp_data | output | DATA_W | Supplied dirty word |

## Verification
The bench targets the ordering hazards. It covers a shared-and-dirty line being upgraded: a design that refills from the bus there would lose the only up-to-date copy. It covers a victim that a snooped write miss invalidates while its write-back waits for the bus: a wrong design would push stale data to memory. It covers a snoop to the same line index as a pending write: if the local write were not stalled, the order of writes would break. It also checks that a line filled while the shared-line is high really stays shared, that snooped write-backs are ignored, and that a reset in mid-run clears every line.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WB    = 2'd1,
    ST_ISSUE = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/snp_line_array.sv
module snp_line_array #(
  parameter int IDX_W  = 2,
  parameter int LINE_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [LINE_W-1:0] ra_line,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [LINE_W-1:0] rb_line,
  input  logic              wa_en,
  input  logic [IDX_W-1:0]  wa_idx,
  input  logic [LINE_W-1:0] wa_line,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [LINE_W-1:0] wb_line
);
  localparam int LINES = 1 << IDX_W;

  logic [LINE_W-1:0] mem [LINES];

  // Snoop port (b) wins over the controller port (a) on the same line.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mem[g] <= '0;
      else if (wb_en && wb_idx == IDX_W'(g))     mem[g] <= wb_line;
      else if (wa_en && wa_idx == IDX_W'(g))     mem[g] <= wa_line;
    end
  end

  assign ra_line = mem[ra_idx];
  assign rb_line = mem[rb_idx];
endmodule

// File: rtl/snp_snoop_unit.sv
module snp_snoop_unit import snp_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [3+ADDR_W-IDX_W+DATA_W-1:0] line_in,
  output logic [IDX_W-1:0]  snp_idx,
  output logic              snp_shared,
  output logic              snp_abort,
  output logic [DATA_W-1:0] snp_data,
  output logic              upd_en,
  output logic [3+ADDR_W-IDX_W+DATA_W-1:0] upd_line
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef struct packed {
    logic              valid;
    logic              excl;
    logic              dirty;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } line_t;

  line_t cur, nxt;
  logic  match, is_rd, is_wr;

  assign cur     = line_t'(line_in);
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign is_rd   = snp_valid && (bus_cmd_e'(snp_cmd) == CMD_RD);
  assign is_wr   = snp_valid && (bus_cmd_e'(snp_cmd) == CMD_WR);
  assign match   = cur.valid && (cur.tag == snp_addr[ADDR_W-1:IDX_W]);

  always_comb begin
    nxt        = cur;
    upd_en     = 1'b0;
    snp_shared = 1'b0;
    snp_abort  = 1'b0;
    if (match && (is_rd || is_wr)) begin
      upd_en    = 1'b1;
      snp_abort = cur.dirty;
      if (is_rd) begin
        snp_shared = 1'b1;
        nxt.excl   = 1'b0;     // ownership drops to shared, dirty kept
      end else begin
        nxt.valid  = 1'b0;
        nxt.excl   = 1'b0;
        nxt.dirty  = 1'b0;
      end
    end
  end

  assign snp_data = cur.data;
  assign upd_line = nxt;

  // R8: abort only in answer to a snooped miss
  p_abort_needs_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2)));

  // R12: snooped write-backs change nothing
  p_wb_snoop_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 2'd3) |-> (!snp_shared && !snp_abort && !upd_en));
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl import snp_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_abort,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int LINE_W = 3 + TAG_W + DATA_W;

  typedef struct packed {
    logic              valid;
    logic              excl;
    logic              dirty;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } line_t;

  ctl_state_e        state, nxt_state;
  bus_cmd_e          cmd_c;
  line_t             ent_c, wa_line;
  logic [LINE_W-1:0] ra_raw, rb_raw, upd_raw;
  logic              wa_en, upd_en;
  logic [IDX_W-1:0]  idx_c, snp_idx;
  logic [TAG_W-1:0]  tag_c;
  logic              tag_hit, clash, victim_dirty;

  assign idx_c = cpu_addr[IDX_W-1:0];
  assign tag_c = cpu_addr[ADDR_W-1:IDX_W];
  assign ent_c = line_t'(ra_raw);

  snp_line_array #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(idx_c), .ra_line(ra_raw),
    .rb_idx(snp_idx), .rb_line(rb_raw),
    .wa_en(wa_en), .wa_idx(idx_c), .wa_line(wa_line),
    .wb_en(upd_en), .wb_idx(snp_idx), .wb_line(upd_raw)
  );

  snp_snoop_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .line_in(rb_raw), .snp_idx(snp_idx),
    .snp_shared(snp_shared), .snp_abort(snp_abort), .snp_data(snp_data),
    .upd_en(upd_en), .upd_line(upd_raw)
  );

  assign tag_hit      = ent_c.valid && (ent_c.tag == tag_c);
  assign clash        = snp_valid && (snp_idx == idx_c);
  assign victim_dirty = ent_c.valid && ent_c.dirty && !tag_hit;

  always_comb begin
    nxt_state = state;
    cpu_ready = 1'b0;
    bus_req   = 1'b0;
    cmd_c     = CMD_NONE;
    bus_addr  = cpu_addr;
    bus_wdata = '0;
    wa_en     = 1'b0;
    wa_line   = ent_c;
    unique case (state)
      ST_IDLE: begin
        cpu_ready = cpu_valid && !clash && tag_hit && (!cpu_wr || ent_c.excl);
        if (cpu_ready && cpu_wr) begin
          wa_en         = 1'b1;
          wa_line.data  = cpu_wdata;
          wa_line.dirty = 1'b1;
        end else if (cpu_valid && !clash && !cpu_ready) begin
          nxt_state = victim_dirty ? ST_WB : ST_ISSUE;
        end
      end
      ST_WB: begin
        bus_req = victim_dirty;
        if (!victim_dirty) begin
          nxt_state = ST_ISSUE;          // victim lost to a snoop: skip write-back
        end else if (bus_gnt) begin
          cmd_c         = CMD_WB;
          bus_addr      = {ent_c.tag, idx_c};
          bus_wdata     = ent_c.data;
          wa_en         = 1'b1;
          wa_line.valid = 1'b0;
          wa_line.excl  = 1'b0;
          wa_line.dirty = 1'b0;
          nxt_state     = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        bus_req = 1'b1;
        if (bus_gnt) begin
          cmd_c         = cpu_wr ? CMD_WR : CMD_RD;
          wa_en         = 1'b1;
          wa_line.valid = 1'b1;
          wa_line.tag   = tag_c;
          if (cpu_wr) begin
            wa_line.excl = 1'b1;
            if (!tag_hit) begin
              wa_line.data  = bus_fill_data;
              wa_line.dirty = 1'b0;
            end
          end else begin
            wa_line.excl  = !bus_shared_in;
            wa_line.data  = bus_fill_data;
            wa_line.dirty = 1'b0;
          end
          nxt_state = ST_IDLE;
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt_state;
  end

  assign bus_cmd   = cmd_c;
  assign cpu_rdata = ent_c.data;

  // R6: no transaction without the bus
  p_cmd_only_on_gnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0) |-> bus_gnt);

  // R6: a waiting fill keeps requesting
  p_fill_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ISSUE && !bus_gnt) |=> bus_req);

  // R10: a write-back is always followed by the fill request
  p_fill_after_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'd3) |=> (bus_req && state == ST_ISSUE));

  // R11: a snoop on the same index blocks completion
  p_stall_on_clash_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && snp_valid && snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]) |-> !cpu_ready);

  // R4: a completing request never occupies the bus
  p_hit_is_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (!bus_req && bus_cmd == 2'd0));

  // R2: an unanswered request holds its fields
  p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_ready) |=> (cpu_valid && $stable(cpu_addr) && $stable(cpu_wr)));
endmodule

// File: tb/snoop_cache_ctrl_test.sv
module snoop_cache_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_valid = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_addr = '0, cpu_wdata = '0;
  logic       cpu_ready;
  logic [7:0] cpu_rdata;
  logic       bus_req, bus_gnt = 1'b0;
  logic [1:0] bus_cmd;
  logic [7:0] bus_addr, bus_wdata;
  logic [7:0] bus_fill_data = '0;
  logic       bus_shared_in = 1'b0;
  logic       snp_valid = 1'b0;
  logic [1:0] snp_cmd = '0;
  logic [7:0] snp_addr = '0;
  logic       snp_shared, snp_abort;
  logic [7:0] snp_data;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  snoop_cache_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_fill_data(bus_fill_data), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_abort(snp_abort), .snp_data(snp_data)
  );

  typedef struct packed {
    logic       v, w; logic [7:0] a, wd; logic g; logic [7:0] fill; logic sh;
    logic       sv; logic [1:0] sc; logic [7:0] sa;
    logic       e_rdy; logic [7:0] e_rd; logic e_req; logic [1:0] e_cmd;
    logic [7:0] e_ba, e_bwd; logic e_ssh, e_sab; logic [7:0] e_sd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 33;
  // fields: v w a wd g fill sh sv sc sa | rdy rd req cmd ba bwd ssh sab sd | req
  localparam vec_t VECS [NV] = '{
    '{1,0,8'h05,8'h00,0,8'h00,0, 0,0,8'h00, 0,8'h00,0,0,8'h00,8'h00,0,0,8'h00, 3}, // R3 miss
    '{1,0,8'h05,8'h00,0,8'h00,0, 0,0,8'h00, 0,8'h00,1,0,8'h00,8'h00,0,0,8'h00, 6}, // R6 wait
    '{1,0,8'h05,8'h00,1,8'hAA,0, 0,0,8'h00, 0,8'h00,1,1,8'h05,8'h00,0,0,8'h00, 3}, // R3 fill excl
    '{1,0,8'h05,8'h00,0,8'h00,0, 0,0,8'h00, 1,8'hAA,0,0,8'h00,8'h00,0,0,8'h00, 2}, // R2 hit
    '{1,1,8'h05,8'h11,0,8'h00,0, 0,0,8'h00, 1,8'h00,0,0,8'h00,8'h00,0,0,8'h00, 4}, // R4
    '{0,0,8'h00,8'h00,0,8'h00,0, 1,1,8'h05, 0,8'h00,0,0,8'h00,8'h00,1,1,8'h11, 8}, // R8 R7
    '{1,1,8'h05,8'h22,0,8'h00,0, 0,0,8'h00, 0,8'h00,0,0,8'h00,8'h00,0,0,8'h00, 7}, // R7 now shared
    '{1,1,8'h05,8'h22,1,8'h00,0, 0,0,8'h00, 0,8'h00,1,2,8'h05,8'h00,0,0,8'h00, 5}, // R5 upgrade
    '{1,1,8'h05,8'h22,0,8'h00,0, 0,0,8'h00, 1,8'h00,0,0,8'h00,8'h00,0,0,8'h00, 5}, // R5 done
    '{0,0,8'h00,8'h00,0,8'h00,0, 1,2,8'h05, 0,8'h00,0,0,8'h00,8'h00,0,1,8'h22, 8}, // R8 wr snoop
    '{1,0,8'h05,8'h00,0,8'h00,0, 0,0,8'h00, 0,8'h00,0,0,8'h00,8'h00,0,0,8'h00, 9}, // R9 invalid
    '{1,0,8'h05,8'h00,1,8'h33,1, 0,0,8'h00, 0,8'h00,1,1,8'h05,8'h00,0,0,8'h00, 3}, // R3 shared
    '{1,0,8'h05,8'h00,0,8'h00,0, 0,0,8'h00, 1,8'h33,0,0,8'h00,8'h00,0,0,8'h00, 3},
    '{0,0,8'h00,8'h00,0,8'h00,0, 1,3,8'h05, 0,8'h00,0,0,8'h00,8'h00,0,0,8'h00,12}, // R12
    '{0,0,8'h00,8'h00,0,8'h00,0, 1,1,8'h05, 0,8'h00,0,0,8'h00,8'h00,1,0,8'h00, 7}, // R7 clean
    '{1,1,8'h05,8'h44,0,8'h00,0, 0,0,8'h00, 0,8'h00,0,0,8'h00,8'h00,0,0,8'h00, 3}, // R3 was shared
    '{1,1,8'h05,8'h44,1,8'h00,0, 0,0,8'h00, 0,8'h00,1,2,8'h05,8'h00,0,0,8'h00, 5},
    '{1,1,8'h05,8'h44,0,8'h00,0, 0,0,8'h00, 1,8'h00,0,0,8'h00,8'h00,0,0,8'h00, 5},
    '{1,0,8'h09,8'h00,0,8'h00,0, 0,0,8'h00, 0,8'h00,0,0,8'h00,8'h00,0,0,8'h00,10}, // R10 evict
    '{1,0,8'h09,8'h00,0,8'h00,0, 0,0,8'h00, 0,8'h00,1,0,8'h00,8'h00,0,0,8'h00, 6},
    '{1,0,8'h09,8'h00,1,8'h00,0, 0,0,8'h00, 0,8'h00,1,3,8'h05,8'h44,0,0,8'h00,10}, // R10 WB
    '{1,0,8'h09,8'h00,1,8'h55,0, 0,0,8'h00, 0,8'h00,1,1,8'h09,8'h00,0,0,8'h00,10},
    '{1,0,8'h09,8'h00,0,8'h00,0, 0,0,8'h00, 1,8'h55,0,0,8'h00,8'h00,0,0,8'h00,10},
    '{1,0,8'h09,8'h00,0,8'h00,0, 1,1,8'h0D, 0,8'h00,0,0,8'h00,8'h00,0,0,8'h00,11}, // R11 clash
    '{1,0,8'h09,8'h00,0,8'h00,0, 0,0,8'h00, 1,8'h55,0,0,8'h00,8'h00,0,0,8'h00,11},
    '{1,1,8'h02,8'h66,0,8'h00,0, 0,0,8'h00, 0,8'h00,0,0,8'h00,8'h00,0,0,8'h00,13}, // R13
    '{1,1,8'h02,8'h66,1,8'h77,0, 0,0,8'h00, 0,8'h00,1,2,8'h02,8'h00,0,0,8'h00,13},
    '{1,1,8'h02,8'h66,0,8'h00,0, 1,0,8'h00, 1,8'h00,0,0,8'h00,8'h00,0,0,8'h00,13},
    '{1,0,8'h02,8'h00,0,8'h00,0, 0,0,8'h00, 1,8'h66,0,0,8'h00,8'h00,0,0,8'h00,13},
    '{0,0,8'h00,8'h00,0,8'h00,0, 1,1,8'h09, 0,8'h00,0,0,8'h00,8'h00,1,0,8'h00, 7}, // R7 demote
    '{1,1,8'h09,8'h88,0,8'h00,0, 0,0,8'h00, 0,8'h00,0,0,8'h00,8'h00,0,0,8'h00, 7},
    '{1,1,8'h09,8'h88,1,8'h00,0, 0,0,8'h00, 0,8'h00,1,2,8'h09,8'h00,0,0,8'h00, 5},
    '{1,1,8'h09,8'h88,0,8'h00,0, 0,0,8'h00, 1,8'h00,0,0,8'h00,8'h00,0,0,8'h00, 4}
  };

  task automatic step(input vec_t t);
    logic bad;
    @(negedge clk);
    cpu_valid = t.v; cpu_wr = t.w; cpu_addr = t.a; cpu_wdata = t.wd;
    bus_gnt = t.g; bus_fill_data = t.fill; bus_shared_in = t.sh;
    snp_valid = t.sv; snp_cmd = t.sc; snp_addr = t.sa;
    #1;
    bad = (cpu_ready !== t.e_rdy) || (bus_req !== t.e_req) || (bus_cmd !== t.e_cmd) ||
          (snp_shared !== t.e_ssh) || (snp_abort !== t.e_sab);
    if (t.e_rdy && !t.w && cpu_rdata !== t.e_rd) bad = 1'b1;
    if (t.e_cmd != 2'd0 && bus_addr !== t.e_ba) bad = 1'b1;
    if (t.e_cmd == 2'd3 && bus_wdata !== t.e_bwd) bad = 1'b1;
    if (t.e_sab && snp_data !== t.e_sd) bad = 1'b1;
    n_vec++;
    if (bad) begin
      n_bad++;
      $display("FAIL R%0d vec %0d: got rdy=%b rd=%h req=%b cmd=%0d ba=%h bwd=%h ssh=%b sab=%b sd=%h; exp rdy=%b rd=%h req=%b cmd=%0d ba=%h bwd=%h ssh=%b sab=%b sd=%h",
        t.req, n_vec, cpu_ready, cpu_rdata, bus_req, bus_cmd, bus_addr, bus_wdata, snp_shared, snp_abort, snp_data,
        t.e_rdy, t.e_rd, t.e_req, t.e_cmd, t.e_ba, t.e_bwd, t.e_ssh, t.e_sab, t.e_sd);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: run did not finish (got hang, expected completion)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet after reset
    step('{0,0,8'h00,8'h00,0,8'h00,0, 0,0,8'h00, 0,8'h00,0,0,8'h00,8'h00,0,0,8'h00, 1});
    for (int i = 0; i < NV; i++) step(VECS[i]);
    // R10: victim invalidated by snooped write miss while write-back waits
    step('{1,0,8'h06,8'h00,0,8'h00,0, 0,0,8'h00, 0,8'h00,0,0,8'h00,8'h00,0,0,8'h00,10});
    step('{1,0,8'h06,8'h00,0,8'h00,0, 1,2,8'h02, 0,8'h00,1,0,8'h00,8'h00,0,1,8'h66, 8});
    step('{1,0,8'h06,8'h00,0,8'h00,0, 0,0,8'h00, 0,8'h00,0,0,8'h00,8'h00,0,0,8'h00,10});
    step('{1,0,8'h06,8'h00,1,8'h99,1, 0,0,8'h00, 0,8'h00,1,1,8'h06,8'h00,0,0,8'h00,10});
    step('{1,0,8'h06,8'h00,0,8'h00,0, 0,0,8'h00, 1,8'h99,0,0,8'h00,8'h00,0,0,8'h00, 3});
    // R1: reset in mid-run drops every line
    @(negedge clk);
    cpu_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step('{1,0,8'h06,8'h00,0,8'h00,0, 0,0,8'h00, 0,8'h00,0,0,8'h00,8'h00,0,0,8'h00, 1});
    step('{1,0,8'h06,8'h00,0,8'h00,0, 0,0,8'h00, 0,8'h00,1,0,8'h00,8'h00,0,0,8'h00, 1});
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule